// File: doc/BRIEF.md
# I2C Target with Clock-Stretch Control

This block is the target (slave) side of an I2C bus. It watches the serial clock and data lines, finds START and STOP conditions, and shifts in address bytes. It acknowledges its own 7-bit or 10-bit address, and it can also acknowledge every address or the general call. After that it receives data bytes or sends them. The bus outputs are open-drain enables: a 1 pulls the line low.

A small control register sets the behaviour: enable, address width, accept-all, general-call response and stretch mode. It also holds a clock-release bit. While that bit is 0 the target holds SCL low. Hardware clears the bit at fixed byte boundaries, and software sets it again once it has dealt with the byte. A one-cycle event pulse marks each address match and each completed data byte. Received bytes appear on a data output. Bytes to send are read from a data input while the clock is held.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: While the enable bit (`cfg_wdata[5]`) is 0, `scl_oe` and `sda_oe` stay 0 and no address is acknowledged.
- R2: After reset `cfg_rdata` reads 6'b000001: release (bit 0) is 1 and stretch (bit 1), general call (bit 2), accept-all (bit 3), 10-bit (bit 4) and enable (bit 5) are 0. `scl_oe`, `sda_oe` and `irq` are 0.
- R3: In the ACK slot of every acknowledged address byte, hardware clears the release bit, so SCL is held low until software writes release = 1.
- R4: At the start of every transmitted data byte, hardware clears the release bit. `tx_data` is taken while SCL is held, and the byte is sent MSB first.
- R5: With stretch = 1, the release bit is also cleared after every received data byte, and a software write of release = 0 clears the bit and holds SCL.
- R6: With stretch = 0, a software write of release = 0 is ignored and a received data byte does not stretch the clock.
- R7: In 7-bit mode the first byte's bits [7:1] are compared with `own_addr[6:0]` (bit 0 = 1 means read). Only a match is acknowledged.
- R8: In 10-bit mode the first byte must be 11110 `own_addr[9:8]` 0 and the second byte must equal `own_addr[7:0]`, and both are acknowledged only when they match. A later repeated START with 11110 `own_addr[9:8]` 1 starts a read, but only if a full match has occurred since the last STOP. A 7-bit style address is not acknowledged.
- R9: With accept-all = 1, every address byte is acknowledged.
- R10: With general call = 1, the byte 0x00 is acknowledged and raises `irq`. With general call = 0 (and accept-all = 0) it is not acknowledged.
- R11: A STOP returns the engine to idle and sets the release bit to 1. Bits clocked after a STOP, with no new START, are not acknowledged and raise no event.
- R12: `irq` is a one-cycle pulse after each final address match and after each data byte, received or sent. `rx_data` holds the last received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | Control write data (bit fields as in R2) |
| cfg_rdata | output | 6 | Control register contents |
| own_addr | input | 10 | Own target address |
| tx_data | input | 8 | Byte to transmit on a read |
| rx_data | output | 8 | Last received data byte |
| irq | output | 1 | One-cycle event pulse |

## Verification
The bench builds the block with its default two-stage synchronizer and drives the bus with a quarter-bit of six clocks. It uses own address 0x5A in 7-bit mode and 0x2B7 in 10-bit mode. The small 7-bit address space makes it possible to sweep all 128 addresses, once with exact matching and once with accept-all. The 10-bit tests cover all four header values and every single-bit flip of the low address byte. Stretching is seen directly on the bus: the bench measures how long SCL stays low after its master model releases it.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CFG_W  = 6;
  localparam int CFG_REL = 0;
  localparam int CFG_STR = 1;
  localparam int CFG_GCE = 2;
  localparam int CFG_ANY = 3;
  localparam int CFG_TEN = 4;
  localparam int CFG_EN  = 5;
  localparam logic [4:0] TEN_HDR = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADR1, ST_ADR2, ST_RXB, ST_TXB, ST_ACK, ST_ATX
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dprev
);
  logic [WIDTH-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout  = pipe[STAGES-1];
  assign dprev = pipe[STAGES];
endmodule

// File: rtl/i2c_tgt_ctl.sv
module i2c_tgt_ctl import i2c_tgt_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             hw_clr,
  input  logic             hw_set,
  output logic [CFG_W-1:0] cfg
);
  localparam logic [CFG_W-1:0] RST_VAL = CFG_W'(1) << CFG_REL;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= RST_VAL;
    end else begin
      if (wr) begin
        cfg[CFG_W-1:1] <= wdata[CFG_W-1:1];
        if (cfg[CFG_STR] || wdata[CFG_REL]) cfg[CFG_REL] <= wdata[CFG_REL];
      end
      if (hw_set) cfg[CFG_REL] <= 1'b1;
      if (hw_clr) cfg[CFG_REL] <= 1'b0;
    end
  end

  assert_hw_clear_R3: assert property (@(posedge clk) disable iff (rst)
    hw_clr |=> !cfg[CFG_REL]);

  assert_zero_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && !cfg[CFG_STR] && !wdata[CFG_REL] && !hw_clr && !hw_set)
      |=> cfg[CFG_REL] == $past(cfg[CFG_REL]));
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match import i2c_tgt_pkg::*; (
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own,
  input  logic              ten_bit,
  input  logic              any_addr,
  input  logic              gc_en,
  input  logic              armed,
  output logic              hit_full,
  output logic              hit_high,
  output logic              hit_low
);
  logic gc, hdr, short_hit;

  always_comb begin
    gc        = gc_en && (rx_byte == '0);
    hdr       = (rx_byte[7:3] == TEN_HDR) && (rx_byte[2:1] == own[9:8]);
    short_hit = !ten_bit && (rx_byte[7:1] == own[6:0]);
    hit_full  = any_addr || gc || short_hit || (ten_bit && hdr && rx_byte[0] && armed);
    hit_high  = ten_bit && hdr && !rx_byte[0] && !any_addr;
    hit_low   = (rx_byte == own[7:0]);
  end

  always_comb begin
    assert_single_path_R8: assert (!(hit_full && hit_high));
  end
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch import i2c_tgt_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [BYTE_W-1:0] rx_data,
  output logic              irq
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  logic [1:0] s_now, s_prev;
  logic s_scl, s_sda, p_scl, p_sda;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic [CFG_W-1:0] cfg;
  logic en, rel, hw_clr, hw_set;
  logic hit_full, hit_high, hit_low;

  tgt_state_e state, st_n, ack_nx, ack_nx_n;
  logic [BYTE_W-1:0] shreg, sh_n, rx_q, rx_n;
  logic [CW-1:0] bitcnt, cnt_n;
  logic armed, armed_n, nack, nack_n, sda_q, sda_n, irq_q, irq_n;

  i2c_tgt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({scl_i, sda_i}), .dout(s_now), .dprev(s_prev));

  assign {s_scl, s_sda} = s_now;
  assign {p_scl, p_sda} = s_prev;
  assign start_det = s_scl && p_scl && p_sda && !s_sda;
  assign stop_det  = s_scl && p_scl && !p_sda && s_sda;
  assign scl_rise  = s_scl && !p_scl;
  assign scl_fall  = !s_scl && p_scl;

  i2c_tgt_ctl u_ctl (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .hw_clr(hw_clr), .hw_set(hw_set), .cfg(cfg));

  assign en  = cfg[CFG_EN];
  assign rel = cfg[CFG_REL];

  i2c_tgt_match u_match (
    .rx_byte(shreg), .own(own_addr), .ten_bit(cfg[CFG_TEN]),
    .any_addr(cfg[CFG_ANY]), .gc_en(cfg[CFG_GCE]), .armed(armed),
    .hit_full(hit_full), .hit_high(hit_high), .hit_low(hit_low));

  always_comb begin
    st_n = state; ack_nx_n = ack_nx; sh_n = shreg; rx_n = rx_q; cnt_n = bitcnt;
    armed_n = armed; nack_n = nack; sda_n = sda_q;
    irq_n = 1'b0; hw_clr = 1'b0; hw_set = 1'b0;
    if (!en) begin
      st_n = ST_IDLE; sda_n = 1'b0; armed_n = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE; sda_n = 1'b0; armed_n = 1'b0; hw_set = 1'b1;
    end else if (start_det) begin
      st_n = ST_ADR1; cnt_n = '0; sda_n = 1'b0;
    end else begin
      unique case (state)
        ST_ADR1, ST_ADR2, ST_RXB: begin
          if (scl_rise) begin
            sh_n  = {shreg[BYTE_W-2:0], s_sda};
            cnt_n = bitcnt + CW'(1);
          end else if (scl_fall && bitcnt == CNT_FULL) begin
            cnt_n = '0;
            if (state == ST_ADR1) begin
              if (hit_full) begin
                st_n = ST_ACK; ack_nx_n = shreg[0] ? ST_TXB : ST_RXB;
                sda_n = 1'b1; hw_clr = 1'b1; irq_n = 1'b1;
              end else if (hit_high) begin
                st_n = ST_ACK; ack_nx_n = ST_ADR2; sda_n = 1'b1; hw_clr = 1'b1;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (state == ST_ADR2) begin
              if (hit_low) begin
                st_n = ST_ACK; ack_nx_n = ST_RXB; armed_n = 1'b1;
                sda_n = 1'b1; hw_clr = 1'b1; irq_n = 1'b1;
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              rx_n = shreg; irq_n = 1'b1; st_n = ST_ACK; ack_nx_n = ST_RXB;
              sda_n = 1'b1; hw_clr = cfg[CFG_STR];
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st_n = ack_nx; cnt_n = '0; sda_n = 1'b0;
            if (ack_nx == ST_TXB) begin
              hw_clr = 1'b1; sh_n = tx_data; sda_n = !tx_data[BYTE_W-1];
            end
          end
        end
        ST_TXB: begin
          if (scl_fall) begin
            cnt_n = bitcnt + CW'(1);
            if (bitcnt == CNT_LAST) begin
              st_n = ST_ATX; sda_n = 1'b0; irq_n = 1'b1;
            end else begin
              sh_n = shreg << 1; sda_n = !shreg[BYTE_W-2];
            end
          end else if (bitcnt == '0 && !rel) begin
            sh_n = tx_data; sda_n = !tx_data[BYTE_W-1];
          end
        end
        ST_ATX: begin
          if (scl_rise) begin
            nack_n = s_sda;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (nack) begin
              st_n = ST_IDLE;
            end else begin
              st_n = ST_TXB; hw_clr = 1'b1; sh_n = tx_data; sda_n = !tx_data[BYTE_W-1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; ack_nx <= ST_IDLE; shreg <= '0; rx_q <= '0; bitcnt <= '0;
      armed <= 1'b0; nack <= 1'b0; sda_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      state <= st_n; ack_nx <= ack_nx_n; shreg <= sh_n; rx_q <= rx_n; bitcnt <= cnt_n;
      armed <= armed_n; nack <= nack_n; sda_q <= sda_n; irq_q <= irq_n;
    end
  end

  assign scl_oe    = en && !rel;
  assign sda_oe    = sda_q;
  assign irq       = irq_q;
  assign rx_data   = rx_q;
  assign cfg_rdata = cfg;

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_oe);

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (rst)
    (en && stop_det) |=> !scl_oe);

  assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: tb/i2c_tgt_stretch_bench.sv
module i2c_tgt_stretch_bench;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic scl_bus, sda_bus, scl_oe, sda_oe, cfg_wr = 1'b0, irq;
  logic [5:0] cfg_wdata = '0, cfg_rdata, shadow = 6'b000001;
  logic [9:0] own_addr = 10'h05A;
  logic [7:0] tx_data = '0, rx_data;

  assign scl_bus = !(m_scl_lo || scl_oe);
  assign sda_bus = !(m_sda_lo || sda_oe);

  i2c_tgt_stretch u_i2c_tgt_stretch (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .own_addr(own_addr), .tx_data(tx_data), .rx_data(rx_data), .irq(irq));

  int checks = 0, errors = 0, irq_cnt = 0;
  bit oe_seen = 1'b0;
  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (scl_oe || sda_oe) oe_seen <= 1'b1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [5:0] v);
    shadow = v;
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic scl_up(output bit st);
    m_scl_lo = 1'b0; st = 1'b0;
    @(negedge clk);
    for (int n = 1; n < 4000 && !scl_bus; n++) begin
      st = 1'b1;
      if (n == 20) begin
        cfg_wr = 1'b1; cfg_wdata = shadow | 6'b000001;
        @(negedge clk); cfg_wr = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic send_bit(input bit b, output bit st);
    m_sda_lo = !b; half(); scl_up(st); half(); m_scl_lo = 1'b1; half();
  endtask

  task automatic get_bit(output bit b, output bit st);
    m_sda_lo = 1'b0; half(); scl_up(st); half(); b = sda_bus; m_scl_lo = 1'b1; half();
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack, output bit st);
    bit s;
    for (int i = 7; i >= 0; i--) send_bit(d[i], s);
    get_bit(ack, st);
  endtask

  task automatic rbyte(output logic [7:0] d, input bit ackb, output bit st0);
    bit b, s;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b, s);
      if (i == 7) st0 = s;
      d[i] = b;
    end
    send_bit(ackb, s);
  endtask

  task automatic bstart();
    bit s;
    m_sda_lo = 1'b0; half(); scl_up(s); half(); m_sda_lo = 1'b1; half(); m_scl_lo = 1'b1; half();
  endtask

  task automatic bstop();
    bit s;
    m_sda_lo = 1'b1; half(); scl_up(s); half(); m_sda_lo = 1'b0; half();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack, ack2, st, st2, s;
    logic [7:0] d;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk("R2 cfg_rdata", cfg_rdata, 6'h01);
    chk("R2 oe", {scl_oe, sda_oe, irq}, 0);

    // R1 disabled target
    wr_cfg(6'b000001); oe_seen = 1'b0;
    bstart(); wbyte({7'h5A, 1'b0}, ack, st); bstop();
    chk("R1 nack when off", ack, 1);
    chk("R1 lines undriven", oe_seen, 0);

    // R7 sweep of all 7-bit addresses, R3 stretch in address ACK
    wr_cfg(6'b100001);
    for (int a = 0; a < 128; a++) begin
      base = irq_cnt;
      bstart(); wbyte({7'(a), 1'b0}, ack, st); bstop();
      chk($sformatf("R7 ack addr %0h", a), ack, (a == 'h5A) ? 0 : 1);
      if (a == 'h5A) begin
        chk("R3 address stretch", st, 1);
        chk("R12 irq on match", irq_cnt - base, 1);
        chk("R11 release after stop", cfg_rdata[0], 1);
      end
    end

    // R10 general call
    bstart(); wbyte(8'h00, ack, st); bstop();
    chk("R10 gc disabled", ack, 1);
    wr_cfg(6'b100101); base = irq_cnt;
    bstart(); wbyte(8'h00, ack, st); bstop();
    chk("R10 gc ack", ack, 0);
    chk("R10 gc irq", irq_cnt - base, 1);

    // R9 accept-all sweep
    wr_cfg(6'b101001);
    for (int a = 0; a < 128; a++) begin
      bstart(); wbyte({7'(a), 1'b0}, ack, st); bstop();
      chk($sformatf("R9 ack addr %0h", a), ack, 0);
    end

    // R6 no data stretch, zero write ignored
    wr_cfg(6'b100001); base = irq_cnt;
    bstart(); wbyte(8'hB4, ack, st); wbyte(8'hA5, ack, st); bstop();
    chk("R6 data ack", ack, 0);
    chk("R6 no data stretch", st, 0);
    chk("R12 rx_data", rx_data, 8'hA5);
    chk("R12 irq count write", irq_cnt - base, 2);
    wr_cfg(6'b100000);
    chk("R6 zero write ignored", cfg_rdata[0], 1);
    chk("R6 scl free", scl_oe, 0);
    shadow = 6'b100001;

    // R5 stretch after data, software clear
    wr_cfg(6'b100011); base = irq_cnt;
    bstart(); wbyte(8'hB4, ack, st); wbyte(8'h3C, ack, st); bstop();
    chk("R5 data stretch", st, 1);
    chk("R5 rx_data", rx_data, 8'h3C);
    chk("R5 irq count", irq_cnt - base, 2);
    wr_cfg(6'b100010);
    chk("R5 sw clear", cfg_rdata[0], 0);
    chk("R5 scl held", scl_oe, 1);
    wr_cfg(6'b100011);
    chk("R5 sw release", scl_oe, 0);

    // R11 stop mid-byte then bits with no start
    base = irq_cnt;
    bstart(); wbyte(8'hB4, ack, st);
    send_bit(1'b1, s); send_bit(1'b0, s); send_bit(1'b1, s);
    bstop();
    wbyte(8'hB4, ack, st);
    chk("R11 no ack after stop", ack, 1);
    chk("R11 irq only for address", irq_cnt - base, 1);
    chk("R11 release set", cfg_rdata[0], 1);
    bstop();

    // R4 read
    wr_cfg(6'b100001); base = irq_cnt; tx_data = 8'hC6;
    bstart(); wbyte(8'hB5, ack, st);
    chk("R4 read address ack", ack, 0);
    rbyte(d, 1'b0, st);
    chk("R4 byte 1", d, 8'hC6);
    chk("R4 tx stretch 1", st, 1);
    tx_data = 8'h39;
    rbyte(d, 1'b1, st);
    chk("R4 byte 2", d, 8'h39);
    chk("R4 tx stretch 2", st, 1);
    bstop();
    chk("R12 irq count read", irq_cnt - base, 3);

    // R8 10-bit addressing
    own_addr = 10'h2B7; wr_cfg(6'b110001);
    for (int h = 0; h < 4; h++) begin
      base = irq_cnt;
      bstart(); wbyte({5'b11110, 2'(h), 1'b0}, ack, st);
      chk($sformatf("R8 header %0d", h), ack, (h == 2) ? 0 : 1);
      if (h == 2) begin
        wbyte(8'hB7, ack2, st2);
        chk("R8 low byte ack", ack2, 0);
        chk("R8 irq once", irq_cnt - base, 1);
      end
      bstop();
    end
    for (int k = 0; k < 8; k++) begin
      bstart(); wbyte(8'hF4, ack, st); wbyte(8'hB7 ^ (8'h01 << k), ack2, st2); bstop();
      chk($sformatf("R8 low mismatch bit %0d", k), ack2, 1);
    end
    bstart(); wbyte(8'h6E, ack, st); bstop();
    chk("R8 short address in 10-bit mode", ack, 1);
    bstart(); wbyte(8'hF5, ack, st); bstop();
    chk("R8 read unarmed", ack, 1);
    tx_data = 8'h6E;
    bstart(); wbyte(8'hF4, ack, st); wbyte(8'hB7, ack, st);
    bstart(); wbyte(8'hF5, ack, st);
    chk("R8 read armed", ack, 0);
    rbyte(d, 1'b1, st);
    chk("R8 read data", d, 8'h6E);
    bstop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule